// File: doc/BRIEF.md
# Dual-Mode Timer/Counter Channel

This block is one channel of a classic microcontroller timer/counter. It holds a count split into a low byte and a high byte. When enabled, it advances either once per system clock or once per falling edge seen on an external count pin. It works as a 13-bit counter, which uses the five low bits of the low byte plus the whole high byte, or as a full 16-bit counter. A gate option lets an active-low external interrupt pin pause counting: while that pin is low, the count stops.

When the count wraps to zero, the block sets an overflow flag and raises a pulse that lasts one clock. The flag is cleared by an interrupt-acknowledge strobe, or software loads it directly. Software also writes either count byte. A write wins over an increment that falls in the same cycle.

Two small state machines carry the control. The edge tracker has states `PIN_HIGH` and `PIN_LOW`. The transition *fall* (`PIN_HIGH` to `PIN_LOW`) produces one count event, and *rise* (`PIN_LOW` to `PIN_HIGH`) produces none. The flag machine has states `FLG_CLEAR` and `FLG_SET`. Its transitions are: *raise*, on a wrap or a software write of 1; *drop*, on an acknowledge or a software write of 0 when no wrap occurs; and *hold*, which keeps the current state. A wrap overrides both an acknowledge and a software write in the same cycle.

Top module: `tmr_chan`

## Requirements
- R1: With `mode_wide`=0 the count is {`cnt_hi`, `cnt_lo[4:0]`}, 13 bits, advancing by one per count event and wrapping from 0x1FFF to 0; `cnt_lo[7:5]` carry no meaning in this mode.
- R2: With `mode_wide`=1 the count is {`cnt_hi`, `cnt_lo`}, 16 bits, wrapping from 0xFFFF to 0.
- R3: While `run_en`=0 the count does not change, apart from software writes.
- R4: With `ext_sel`=0 a count event occurs on every clock. With `ext_sel`=1 a count event occurs once per falling edge of `cnt_pin`, after a two-flop synchronizer, and the count changes on the third rising clock edge after the pin falls. A rising edge, or a pin held low, gives no further event.
- R5: With `gate_en`=1 counting also requires `gate_n`=1; with `gate_en`=0, `gate_n` has no effect.
- R6: On a wrap, `ovf_flag` becomes 1 and `ovf_pulse` is 1 for exactly one cycle, both at the same clock edge where the count becomes zero.
- R7: An `ack` strobe clears `ovf_flag` at the next clock, unless a wrap happens in that cycle.
- R8: `flag_wr`=1 loads `ovf_flag` from `flag_wdata` at the next clock, unless a wrap happens in that cycle.
- R9: `wr_lo` / `wr_hi` load `wr_data` into the low / high byte at the next clock. While either is high, no increment and no wrap occur.
- R10: A wrap and an `ack` in the same cycle leave `ovf_flag` set and still produce the pulse.
- R11: After reset both count bytes, `ovf_flag` and `ovf_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable |
| ext_sel | input | 1 | 1: count external pin edges, 0: count clocks |
| gate_en | input | 1 | 1: counting also needs gate_n high |
| gate_n | input | 1 | Active-low external interrupt pin used for gating |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| mode_wide | input | 1 | 1: 16-bit mode, 0: 13-bit mode |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_data | input | 8 | Write data for count bytes |
| flag_wr | input | 1 | Load overflow flag from flag_wdata |
| flag_wdata | input | 1 | Value for a flag write |
| ack | input | 1 | Interrupt-acknowledge strobe |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 5-bit low field in 13-bit mode and a two-stage synchronizer. Preloading the count to within a few steps of all ones brings both the 0x1FFF and 0xFFFF wraps within reach in a handful of cycles. The same preload lets the bench line up an acknowledge, or a write, exactly on the wrap edge. With the two-stage synchronizer, the third-edge latency of an external count is fixed, so the bench can place its samples cycle-exactly around pin edges. Those edges include single-cycle low pulses and a pin held low for a long stretch.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        FLG_CLEAR = 1'b0,
        FLG_SET   = 1'b1
    } flag_state_t;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RESET_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    pin_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_HIGH: if (!pin_i) state_d = PIN_LOW;
            PIN_LOW:  if (pin_i)  state_d = PIN_HIGH;
            default:              state_d = PIN_HIGH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        fall_o = 1'b0;
        unique case (state_q)
            PIN_HIGH: fall_o = !pin_i;
            PIN_LOW:  fall_o = 1'b0;
            default:  fall_o = 1'b0;
        endcase
    end

    // R4: a fall event lasts a single cycle
    p_single_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int BYTE_W  = 8,
    parameter int SHORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              mode_wide_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              wrap_o
);
    localparam int WIDE_W   = 2 * BYTE_W;
    localparam int NARROW_W = SHORT_W + BYTE_W;
    localparam logic [WIDE_W-1:0]   WIDE_ONE   = {{(WIDE_W-1){1'b0}}, 1'b1};
    localparam logic [NARROW_W-1:0] NARROW_ONE = {{(NARROW_W-1){1'b0}}, 1'b1};

    logic [BYTE_W-1:0]   lo_q, hi_q, lo_d, hi_d;
    logic [WIDE_W-1:0]   wide_val, wide_inc;
    logic [NARROW_W-1:0] narrow_val, narrow_inc;
    logic                sw_write;

    assign wide_val   = {hi_q, lo_q};
    assign narrow_val = {hi_q, lo_q[SHORT_W-1:0]};
    assign wide_inc   = wide_val + WIDE_ONE;
    assign narrow_inc = narrow_val + NARROW_ONE;
    assign sw_write   = wr_lo_i || wr_hi_i;

    assign wrap_o = tick_i && !sw_write &&
                    (mode_wide_i ? (&wide_val) : (&narrow_val));

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (sw_write) begin
            if (wr_lo_i) lo_d = wr_data_i;
            if (wr_hi_i) hi_d = wr_data_i;
        end else if (tick_i) begin
            if (mode_wide_i) begin
                {hi_d, lo_d} = wide_inc;
            end else begin
                {hi_d, lo_d[SHORT_W-1:0]} = narrow_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    // R3: without an event or a write the count holds
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !sw_write) |=> ($stable(lo_q) && $stable(hi_q)));
    // R9: a low-byte write lands exactly
    p_write_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (lo_q == $past(wr_data_i)));
    // R9: a high-byte write lands exactly
    p_write_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi_i |=> (hi_q == $past(wr_data_i)));
    // R1: a narrow wrap ends at zero
    p_wrap_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !mode_wide_i) |=> (narrow_val == '0));
    // R2: a wide wrap ends at zero
    p_wrap_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && mode_wide_i) |=> (wide_val == '0));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic ack_i,
    input  logic sw_wr_i,
    input  logic sw_val_i,
    output logic flag_o,
    output logic pulse_o
);
    flag_state_t state_q, state_d;
    logic        pulse_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (wrap_i || (sw_wr_i && sw_val_i)) state_d = FLG_SET;
            end
            FLG_SET: begin
                if (wrap_i)       state_d = FLG_SET;
                else if (sw_wr_i) state_d = sw_val_i ? FLG_SET : FLG_CLEAR;
                else if (ack_i)   state_d = FLG_CLEAR;
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= wrap_i;
    end

    always_comb begin
        flag_o = 1'b0;
        unique case (state_q)
            FLG_CLEAR: flag_o = 1'b0;
            FLG_SET:   flag_o = 1'b1;
            default:   flag_o = 1'b0;
        endcase
    end

    assign pulse_o = pulse_q;

    // R6: the pulse never lasts two cycles
    p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
    // R6: the pulse always comes with the flag
    p_pulse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> flag_o);
    // R7: acknowledge alone clears the flag
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !wrap_i && !sw_wr_i) |=> !flag_o);
    // R8: software load without a wrap
    p_sw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !wrap_i) |=> (flag_o == $past(sw_val_i)));
    // R10: a wrap always leaves the flag set and pulses
    p_wrap_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (flag_o && pulse_o));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
    parameter int BYTE_W      = 8,
    parameter int SHORT_W     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ext_sel,
    input  logic              gate_en,
    input  logic              gate_n,
    input  logic              cnt_pin,
    input  logic              mode_wide,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              ack,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic              ovf_flag,
    output logic              ovf_pulse
);
    logic pin_sync;
    logic pin_fall;
    logic gate_open;
    logic tick;
    logic wrap;

    tmr_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (cnt_pin),
        .q_o  (pin_sync)
    );

    tmr_edge edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_sync),
        .fall_o(pin_fall)
    );

    assign gate_open = !gate_en || gate_n;
    assign tick      = run_en && gate_open && (ext_sel ? pin_fall : 1'b1);

    tmr_count #(
        .BYTE_W (BYTE_W),
        .SHORT_W(SHORT_W)
    ) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .mode_wide_i(mode_wide),
        .wr_lo_i    (wr_lo),
        .wr_hi_i    (wr_hi),
        .wr_data_i  (wr_data),
        .lo_o       (cnt_lo),
        .hi_o       (cnt_hi),
        .wrap_o     (wrap)
    );

    tmr_flag flag_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap),
        .ack_i   (ack),
        .sw_wr_i (flag_wr),
        .sw_val_i(flag_wdata),
        .flag_o  (ovf_flag),
        .pulse_o (ovf_pulse)
    );

    // R5: a closed gate freezes the count at the ports
    p_gate_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !gate_n && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
    // R3: a stopped channel never raises the pulse
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !ovf_pulse);
endmodule

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en, ext_sel, gate_en, gate_n, cnt_pin, mode_wide;
    logic       wr_lo, wr_hi, flag_wr, flag_wdata, ack;
    logic [7:0] wr_data;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag, ovf_pulse;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int         cyc;
        string      tag;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       fl;
        logic       pu;
        bit         m13;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;

    always #4 clk = ~clk;

    tmr_chan dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .ext_sel   (ext_sel),
        .gate_en   (gate_en),
        .gate_n    (gate_n),
        .cnt_pin   (cnt_pin),
        .mode_wide (mode_wide),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .flag_wr   (flag_wr),
        .flag_wdata(flag_wdata),
        .ack       (ack),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .ovf_flag  (ovf_flag),
        .ovf_pulse (ovf_pulse)
    );

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // monitor: pop expectations due this cycle and compare
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].cyc <= cyc_cnt) begin
            logic [7:0] act_lo, exp_lo;
            mon_e  = sb_q.pop_front();
            act_lo = mon_e.m13 ? (cnt_lo & 8'h1F) : cnt_lo;
            exp_lo = mon_e.m13 ? (mon_e.lo & 8'h1F) : mon_e.lo;
            checks++;
            if (act_lo !== exp_lo || cnt_hi !== mon_e.hi ||
                ovf_flag !== mon_e.fl || ovf_pulse !== mon_e.pu) begin
                errors++;
                $display("FAIL %s: actual lo=%h hi=%h flag=%b pulse=%b expected lo=%h hi=%h flag=%b pulse=%b",
                         mon_e.tag, act_lo, cnt_hi, ovf_flag, ovf_pulse,
                         exp_lo, mon_e.hi, mon_e.fl, mon_e.pu);
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_at(input int d, input string tag, input logic [7:0] lo,
                             input logic [7:0] hi, input logic fl, input logic pu,
                             input bit m13 = 1'b0);
        exp_t e;
        e.cyc = cyc_cnt + d;
        e.tag = tag;
        e.lo  = lo;
        e.hi  = hi;
        e.fl  = fl;
        e.pu  = pu;
        e.m13 = m13;
        sb_q.push_back(e);
    endtask

    task automatic load_count(input logic [7:0] hi, input logic [7:0] lo);
        wr_hi = 1'b1; wr_data = hi; step();
        wr_hi = 1'b0; wr_lo = 1'b1; wr_data = lo; step();
        wr_lo = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; ext_sel = 1'b0; gate_en = 1'b0; gate_n = 1'b1;
        cnt_pin = 1'b1; mode_wide = 1'b1; wr_lo = 1'b0; wr_hi = 1'b0; wr_data = 8'h00;
        flag_wr = 1'b0; flag_wdata = 1'b0; ack = 1'b0;
        step(3);
        rst_n = 1'b1;
        expect_at(0, "R11 reset", 8'h00, 8'h00, 1'b0, 1'b0);
        step();

        // R9: plain writes
        load_count(8'hFF, 8'hFD);
        expect_at(0, "R9 load", 8'hFD, 8'hFF, 1'b0, 1'b0);
        // R3: stopped holds
        expect_at(3, "R3 stopped", 8'hFD, 8'hFF, 1'b0, 1'b0);
        step(3);

        // R2 / R4 clock source / R6 flag and single pulse
        run_en = 1'b1;
        expect_at(1, "R4 clock count", 8'hFE, 8'hFF, 1'b0, 1'b0);
        expect_at(2, "R2 at max", 8'hFF, 8'hFF, 1'b0, 1'b0);
        expect_at(3, "R2 R6 wrap", 8'h00, 8'h00, 1'b1, 1'b1);
        expect_at(4, "R6 pulse one cycle", 8'h01, 8'h00, 1'b1, 1'b0);
        step(4);
        run_en = 1'b0;
        expect_at(1, "R3 stop after run", 8'h01, 8'h00, 1'b1, 1'b0);
        step();

        // R7: acknowledge clears flag
        ack = 1'b1;
        expect_at(1, "R7 ack clear", 8'h01, 8'h00, 1'b0, 1'b0);
        step();
        ack = 1'b0;
        step();

        // R9: write overrides increment
        run_en = 1'b1; wr_lo = 1'b1; wr_data = 8'h10;
        expect_at(1, "R9 override", 8'h10, 8'h00, 1'b0, 1'b0);
        expect_at(2, "R9 resume", 8'h11, 8'h00, 1'b0, 1'b0);
        step();
        wr_lo = 1'b0;
        step();
        run_en = 1'b0;
        step();

        // R1: 13-bit wrap
        mode_wide = 1'b0;
        load_count(8'hFF, 8'h1E);
        expect_at(0, "R1 load", 8'h1E, 8'hFF, 1'b0, 1'b0, 1'b1);
        step();
        run_en = 1'b1;
        expect_at(1, "R1 at 0x1FFF", 8'h1F, 8'hFF, 1'b0, 1'b0, 1'b1);
        expect_at(2, "R1 wrap", 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
        step(2);
        run_en = 1'b0;
        expect_at(1, "R1 after wrap", 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
        step();

        // R8 clear, then R10: wrap with ack
        mode_wide = 1'b1;
        flag_wr = 1'b1; flag_wdata = 1'b0;
        expect_at(1, "R8 write 0", 8'h00, 8'h00, 1'b0, 1'b0);
        step();
        flag_wr = 1'b0;
        load_count(8'hFF, 8'hFE);
        step();
        run_en = 1'b1;
        expect_at(1, "R10 setup", 8'hFF, 8'hFF, 1'b0, 1'b0);
        expect_at(2, "R10 wrap with ack", 8'h00, 8'h00, 1'b1, 1'b1);
        expect_at(3, "R10 flag kept", 8'h00, 8'h00, 1'b1, 1'b0);
        step();
        ack = 1'b1;
        step();
        ack = 1'b0; run_en = 1'b0;
        step(2);

        // R8: software set and clear
        flag_wr = 1'b1; flag_wdata = 1'b0;
        expect_at(1, "R8 write 0 again", 8'h00, 8'h00, 1'b0, 1'b0);
        step();
        flag_wdata = 1'b1;
        expect_at(1, "R8 write 1", 8'h00, 8'h00, 1'b1, 1'b0);
        step();
        flag_wdata = 1'b0;
        expect_at(1, "R8 write 0 final", 8'h00, 8'h00, 1'b0, 1'b0);
        step();
        flag_wr = 1'b0;
        step();

        // R5: gating
        gate_en = 1'b1; gate_n = 1'b0; run_en = 1'b1;
        expect_at(1, "R5 gate closed", 8'h00, 8'h00, 1'b0, 1'b0);
        expect_at(3, "R5 gate closed long", 8'h00, 8'h00, 1'b0, 1'b0);
        step(3);
        gate_n = 1'b1;
        expect_at(1, "R5 gate open", 8'h01, 8'h00, 1'b0, 1'b0);
        expect_at(2, "R5 gate open 2", 8'h02, 8'h00, 1'b0, 1'b0);
        step(2);
        run_en = 1'b0; gate_en = 1'b0;
        expect_at(1, "R3 stop after gate", 8'h02, 8'h00, 1'b0, 1'b0);
        step();

        // R4: external edges
        ext_sel = 1'b1; run_en = 1'b1;
        expect_at(2, "R4 ext idle", 8'h02, 8'h00, 1'b0, 1'b0);
        step(2);
        cnt_pin = 1'b0;
        expect_at(2, "R4 before latency", 8'h02, 8'h00, 1'b0, 1'b0);
        expect_at(3, "R4 one fall", 8'h03, 8'h00, 1'b0, 1'b0);
        expect_at(7, "R4 held low", 8'h03, 8'h00, 1'b0, 1'b0);
        step(7);
        cnt_pin = 1'b1;
        expect_at(5, "R4 rise ignored", 8'h03, 8'h00, 1'b0, 1'b0);
        step(5);
        cnt_pin = 1'b0;
        expect_at(3, "R4 short pulse", 8'h04, 8'h00, 1'b0, 1'b0);
        expect_at(6, "R4 short pulse once", 8'h04, 8'h00, 1'b0, 1'b0);
        step();
        cnt_pin = 1'b1;
        step(6);

        while (sb_q.size() > 0) step();
        step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule